// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Controller

This block gathers raw interrupt sources from four peripheral groups and presents them to a host as one active-high interrupt line. Every source is brought into the clock domain through a flop synchronizer. Each source is then qualified as a level or edge event according to its own trigger type and polarity bits, and captured in a sticky latched-status bit. The block combines latched bits with a per-source enable mask to form one pending bit per group. The OR of those pending bits drives the host interrupt.

Software reaches every group through a small synchronous register bus: a 16-bit address, 8-bit write data, a write strobe, a read strobe, and registered read data. Each group owns a bank of registers at fixed offsets from its base: live level, trigger type, high-polarity and low-polarity selects, latched-status acknowledge, enable set, enable clear and latched status. A summary register gives a one-read view of which groups are pending. The first group carries five sources and the other three carry one source each.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every trigger-type, polarity, enable and latched bit is zero, `irq_o` is low, and reads of the summary register and of every bank register other than live level return zero.
- R2: Group bases are 0x0900, 0x2400, 0xC000 and 0xC100. Bank offsets are live level 0x10, type 0x11, high polarity 0x12, low polarity 0x13, acknowledge 0x14, enable set 0x15, enable clear 0x16 and latched 0x18. `rd_data_o` holds the addressed value from the clock edge that samples `rd_i` until the next read. Any unmapped address, including unused offsets inside a bank, reads 0x00.
- R3: The live-level register returns each source after a two-flop synchronizer, with source n of a group on bit n.
- R4: With type bit 1 (edge) and only the high-polarity bit set, a 0-to-1 transition of the synchronized source sets its latched bit, and a 1-to-0 transition does not.
- R5: With type bit 1 and only the low-polarity bit set, a 1-to-0 transition sets the latched bit, and a 0-to-1 transition does not.
- R6: With type bit 1 and both polarity bits set, either transition sets the latched bit.
- R7: With type bit 0 (level), the latched bit is set on every clock in which the source is at the selected level (high for the high-polarity bit, low for the low-polarity bit). An acknowledge issued while that level persists leaves the bit set.
- R8: Writing 1 to a bit of enable set enables that source, and writing 1 to a bit of enable clear disables it. Zero bits have no effect. Reads of either address return the current enable mask.
- R9: Writing 1 to an acknowledge bit clears the matching latched bit, unless a trigger for that source occurs in the same cycle. Zero bits have no effect.
- R10: A latched bit sets whether or not its source is enabled. Summary register 0x0550 bit g (group order 0x0900, 0x2400, 0xC000, 0xC100 from bit 0) is the OR of that group's latched-and-enabled bits. `irq_o` is high exactly when any summary bit is high.
- R11: Bits above a group's source count ignore writes and read as zero. On `src_i`, group 0x0900 occupies bits 4:0 and the other groups occupy bits 5, 6 and 7 in base order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Register address |
| wr_data_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| src_i | input | 8 | Raw interrupt sources, all groups concatenated |
| irq_o | output | 1 | Host interrupt, active high |

## Verification
The hardest case to reach is a collision between an acknowledge and a trigger that persists: the clear must lose. Another is an edge that must not latch because its polarity is not selected. In each case the source level must already sit in the synchronized stage before the register write lands. The stimulus therefore changes `src_i` and waits several cycles before it writes. For an active-low level source, the collision is created by enabling the low-polarity select while the input rests at zero. After the acknowledge, the latched register is read back to show that the bit stayed set.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int NUM_GROUPS = 4;
   localparam int ADDR_W     = 16;
   localparam int DATA_W     = 8;

   localparam logic [7:0] OFF_LIVE  = 8'h10;
   localparam logic [7:0] OFF_TYPE  = 8'h11;
   localparam logic [7:0] OFF_PHI   = 8'h12;
   localparam logic [7:0] OFF_PLO   = 8'h13;
   localparam logic [7:0] OFF_ACK   = 8'h14;
   localparam logic [7:0] OFF_ENSET = 8'h15;
   localparam logic [7:0] OFF_ENCLR = 8'h16;
   localparam logic [7:0] OFF_LATCH = 8'h18;

   localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 16'h0550;

   localparam logic [ADDR_W-1:0] GROUP_BASE [NUM_GROUPS] =
      '{16'h0900, 16'h2400, 16'hC000, 16'hC100};
   localparam int GROUP_WIDTH [NUM_GROUPS] = '{5, 1, 1, 1};

   function automatic int group_lsb(input int g);
      int acc;
      acc = 0;
      for (int k = 0; k < g; k++) acc += GROUP_WIDTH[k];
      return acc;
   endfunction

   function automatic int total_sources();
      return group_lsb(NUM_GROUPS);
   endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] prv_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_agg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("irq_agg_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain[STAGES-1];
   end

   assign lvl_o = chain[STAGES-1];
   assign prv_o = prev_q;

   // R4
   prev_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> prv_o == $past(lvl_o));

endmodule

// File: rtl/irq_agg_group.sv
module irq_agg_group
   import irq_agg_pkg::*;
#(
   parameter int W  = 1,
   parameter int DW = DATA_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  lvl_i,
   input  logic [W-1:0]  prv_i,
   input  logic          wr_i,
   input  logic [7:0]    off_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          pend_o
);

   if (W < 1 || W > DW) begin : g_bad_width
      $error("irq_agg_group: W must be within 1..DW");
   end

   localparam logic [DW-1:0] IMPL = DW'((1 << W) - 1);

   logic [DW-1:0] lvl_x, prv_x, wmask;
   logic [DW-1:0] type_q, phi_q, plo_q, en_q, latch_q;
   logic [DW-1:0] edge_hit, level_hit, trig;
   logic          wr_type, wr_phi, wr_plo, wr_ack, wr_enset, wr_enclr;

   always_comb begin
      lvl_x = '0;
      prv_x = '0;
      lvl_x[W-1:0] = lvl_i;
      prv_x[W-1:0] = prv_i;
   end

   assign wmask    = wdata_i & IMPL;
   assign wr_type  = wr_i && (off_i == OFF_TYPE);
   assign wr_phi   = wr_i && (off_i == OFF_PHI);
   assign wr_plo   = wr_i && (off_i == OFF_PLO);
   assign wr_ack   = wr_i && (off_i == OFF_ACK);
   assign wr_enset = wr_i && (off_i == OFF_ENSET);
   assign wr_enclr = wr_i && (off_i == OFF_ENCLR);

   // trigger qualification
   assign edge_hit  = type_q & ((phi_q & lvl_x & ~prv_x) | (plo_q & ~lvl_x & prv_x));
   assign level_hit = ~type_q & ((phi_q & lvl_x) | (plo_q & ~lvl_x));
   assign trig      = (edge_hit | level_hit) & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q <= '0;
         phi_q  <= '0;
         plo_q  <= '0;
      end else begin
         if (wr_type) type_q <= wmask;
         if (wr_phi)  phi_q  <= wmask;
         if (wr_plo)  plo_q  <= wmask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else if (wr_enset) en_q <= en_q | wmask;
      else if (wr_enclr) en_q <= en_q & ~wmask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q & ~(wr_ack ? wmask : '0)) | trig;
   end

   always_comb begin
      unique case (off_i)
         OFF_LIVE:             rdata_o = lvl_x;
         OFF_TYPE:             rdata_o = type_q;
         OFF_PHI:              rdata_o = phi_q;
         OFF_PLO:              rdata_o = plo_q;
         OFF_ENSET, OFF_ENCLR: rdata_o = en_q;
         OFF_LATCH:            rdata_o = latch_q;
         default:              rdata_o = '0;
      endcase
   end

   assign pend_o = |(latch_q & en_q);

   // R4
   rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & $past(type_q & phi_q & lvl_x & ~prv_x & IMPL))
                == $past(type_q & phi_q & lvl_x & ~prv_x & IMPL)));

   // R8
   en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enclr |=> (en_q & $past(wmask)) == '0);

   // R8
   en_set_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_enset && wmask == '0) |=> $stable(en_q));

   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> (latch_q & $past(wmask) & ~$past(trig)) == '0);

   // R11
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((type_q | phi_q | plo_q | en_q | latch_q) & ~IMPL) == '0);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   input  logic                       wr_i,
   input  logic                       rd_i,
   output logic [DATA_W-1:0]          rd_data_o,
   input  logic [total_sources()-1:0] src_i,
   output logic                       irq_o
);

   localparam int SRC_W = total_sources();

   logic [SRC_W-1:0]      lvl, prv;
   logic [NUM_GROUPS-1:0] hit, pend;
   logic [DATA_W-1:0]     grp_rd [NUM_GROUPS];
   logic [DATA_W-1:0]     rd_next;

   irq_agg_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (src_i),
      .lvl_o (lvl),
      .prv_o (prv)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      localparam int LSB = group_lsb(g);
      localparam int GW  = GROUP_WIDTH[g];
      logic [ADDR_W-1:0] rel;

      assign rel    = addr_i - GROUP_BASE[g];
      assign hit[g] = (rel[ADDR_W-1:5] == '0);

      irq_agg_group #(.W(GW), .DW(DATA_W)) u_grp (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (lvl[LSB +: GW]),
         .prv_i   (prv[LSB +: GW]),
         .wr_i    (wr_i && hit[g]),
         .off_i   (rel[7:0]),
         .wdata_i (wr_data_i),
         .rdata_o (grp_rd[g]),
         .pend_o  (pend[g])
      );
   end

   always_comb begin
      rd_next = '0;
      if (addr_i == SUMMARY_ADDR) rd_next = DATA_W'(pend);
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (hit[g]) rd_next = rd_next | grp_rd[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_data_o <= '0;
      else if (rd_i) rd_data_o <= rd_next;
   end

   assign irq_o = |pend;

   // R10
   summary_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && addr_i == SUMMARY_ADDR) |=> rd_data_o == DATA_W'($past(pend)));

   // R2
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rd_data_o));

   // R2
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && hit == '0 && addr_i != SUMMARY_ADDR) |=> rd_data_o == '0);

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  rdata;
   logic [7:0]  src = '0;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_aggregator u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .wr_i      (wr),
      .rd_i      (rd),
      .rd_data_o (rdata),
      .src_i     (src),
      .irq_o     (irq)
   );

   // op: 0 write, 1 read and compare, 2 drive sources then settle
   localparam int NV = 53;
   localparam logic [25:0] VEC [NV] = '{
      {2'd1, 16'h0550, 8'h00}, // R1
      {2'd1, 16'h0915, 8'h00}, // R1
      {2'd0, 16'h0911, 8'h1F},
      {2'd0, 16'h0912, 8'h1F},
      {2'd0, 16'h0915, 8'h03},
      {2'd2, 16'h0000, 8'h01},
      {2'd1, 16'h0910, 8'h01}, // R3
      {2'd1, 16'h0918, 8'h01}, // R4
      {2'd1, 16'h0550, 8'h01}, // R10
      {2'd2, 16'h0000, 8'h04},
      {2'd1, 16'h0918, 8'h05}, // R4
      {2'd1, 16'h0550, 8'h01}, // R10
      {2'd0, 16'h0914, 8'h01},
      {2'd1, 16'h0918, 8'h04}, // R9
      {2'd1, 16'h0550, 8'h00}, // R10
      {2'd0, 16'h0916, 8'h01},
      {2'd1, 16'h0915, 8'h02}, // R8
      {2'd1, 16'h0916, 8'h02}, // R8
      {2'd0, 16'h0915, 8'h00},
      {2'd1, 16'h0915, 8'h02}, // R8
      {2'd0, 16'h2411, 8'h01},
      {2'd0, 16'h2413, 8'h01},
      {2'd0, 16'h2415, 8'h01},
      {2'd2, 16'h0000, 8'h24},
      {2'd1, 16'h2418, 8'h00}, // R5
      {2'd2, 16'h0000, 8'h04},
      {2'd1, 16'h2418, 8'h01}, // R5
      {2'd1, 16'h0550, 8'h02}, // R10
      {2'd0, 16'hC011, 8'h01},
      {2'd0, 16'hC012, 8'h01},
      {2'd0, 16'hC013, 8'h01},
      {2'd0, 16'hC015, 8'h01},
      {2'd2, 16'h0000, 8'h44},
      {2'd1, 16'hC018, 8'h01}, // R6
      {2'd0, 16'hC014, 8'h01},
      {2'd1, 16'hC018, 8'h00}, // R9
      {2'd2, 16'h0000, 8'h04},
      {2'd1, 16'hC018, 8'h01}, // R6
      {2'd1, 16'h0550, 8'h06}, // R10
      {2'd0, 16'hC113, 8'h01},
      {2'd0, 16'hC115, 8'h01},
      {2'd1, 16'hC118, 8'h01}, // R7
      {2'd0, 16'hC114, 8'h01},
      {2'd1, 16'hC118, 8'h01}, // R7
      {2'd2, 16'h0000, 8'h84},
      {2'd0, 16'hC114, 8'h01},
      {2'd1, 16'hC118, 8'h00}, // R7
      {2'd1, 16'h0550, 8'h06}, // R10
      {2'd1, 16'h1234, 8'h00}, // R2
      {2'd1, 16'h0917, 8'h00}, // R2
      {2'd0, 16'h2412, 8'hFF},
      {2'd1, 16'h2412, 8'h01}, // R11
      {2'd1, 16'h0912, 8'h1F}  // R2
   };
   localparam int VREQ [NV] = '{
      1,1,0,0,0,0,3,4,10,0,4,10,0,9,10,0,8,8,0,8,0,0,0,0,5,0,5,10,
      0,0,0,0,0,6,0,9,0,6,10,0,0,7,0,7,0,0,7,10,2,2,0,11,2};

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic drive_src(input logic [7:0] v);
      @(negedge clk);
      src = v;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      logic [7:0] got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {7'd0, irq}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         unique case (VEC[i][25:24])
            2'd0: bus_write(VEC[i][23:8], VEC[i][7:0]);
            2'd1: begin
               bus_read(VEC[i][23:8], got);
               check($sformatf("R%0d vector %0d", VREQ[i], i), got, VEC[i][7:0]);
            end
            default: drive_src(VEC[i][7:0]);
         endcase
      end

      // R10: pending groups drive the interrupt
      check("R10", {7'd0, irq}, 8'h01);
      // R9: acknowledge remaining pending groups
      bus_write(16'h2414, 8'h01);
      bus_write(16'hC014, 8'h01);
      check("R10", {7'd0, irq}, 8'h00);
      bus_read(16'h2418, got);
      check("R9", got, 8'h00);
      // R8 / R10: enabling an already latched source raises the interrupt
      bus_write(16'h0915, 8'h04);
      check("R10", {7'd0, irq}, 8'h01);
      bus_read(16'h0550, got);
      check("R10", got, 8'h01);
      // R2: read data holds between reads
      repeat (3) @(negedge clk);
      check("R2", rdata, 8'h01);

      // R1: reset clears everything
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", rdata, 8'h00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1", {7'd0, irq}, 8'h00);
      bus_read(16'h0550, got);
      check("R1", got, 8'h00);
      bus_read(16'h0918, got);
      check("R1", got, 8'h00);
      bus_read(16'h0915, got);
      check("R1", got, 8'h00);
      bus_read(16'hC113, got);
      check("R1", got, 8'h00);
      // R3: live level after reset reflects held input bit 7
      bus_read(16'hC110, got);
      check("R3", got, 8'h01);
      bus_read(16'h0910, got);
      check("R3", got, 8'h04);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule